// File: doc/BRIEF.md
# DRAM Cycle Decoder with Test Mode Latch

This block models the control logic on the device side of an asynchronous DRAM. It samples the active-low row strobe, column strobe and write-enable on a fast system clock. It works out what kind of memory cycle the strobes describe from the order in which their edges arrive. The possible cycle types are a normal read, an early write, a refresh with only the row strobe, a refresh with the column strobe low first, and the entry into test mode. The block drives the row and column indices of a small behavioural cell array. For refreshes where the column strobe comes first, it takes the row from an internal refresh counter.

The array hands back both cells that differ only in column bit 9. In normal operation, the block returns the cell selected by that bit. Test mode is a latched flag. While it is set, column bit 9 is ignored, a write goes to both cells, and a read returns a per-pin equality result for the two cells instead of data. Only a refresh cycle clears the flag. Ordinary reads and writes leave it as it is.

All strobes must be synchronous to `clk`. The decoder registers the previous strobe levels and acts on the edges it sees.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `test_mode`=0, `dq_oe`=0, `cyc_valid`=0 and `cyc_type`=0 (none). The refresh counter is 0.
- R2: A row-strobe fall with the column strobe already low and write-enable high is a refresh cycle. The decoder reports `cyc_type`=4 with a one-cycle `cyc_valid` one clock later and clears `test_mode`. `arr_row` takes the refresh counter, and the counter then increments.
- R3: A row-strobe fall with the column strobe low and write-enable low reports `cyc_type`=5 and sets `test_mode`. It also uses and increments the refresh counter.
- R4: `test_mode` keeps its value through read and write cycles. It changes only in a cycle where `cyc_valid` is high.
- R5: A row-strobe low period with no column-strobe fall is a row-only refresh. When the row strobe rises, the decoder reports `cyc_type`=3 and clears `test_mode`.
- R6: Normal read. `arr_row` takes `addr` at the row-strobe fall. At a column-strobe fall with write-enable high, `arr_col` takes `addr[8:0]` and `cyc_type`=1 is reported one clock later. Two clocks after the fall, `dq_oe`=1 and `dq_out` is the half of `rd_pair` picked by `addr[9]` (0 picks bits [7:0], 1 picks bits [15:8]). `dq_oe` returns to 0 one clock after the row strobe rises.
- R7: Early write. Write-enable low at the column-strobe fall reports `cyc_type`=2 and pulses `arr_we` for one clock with `arr_wdata`=`din`. `arr_half_en` is one-hot (bit 0 for `addr[9]`=0, bit 1 for `addr[9]`=1), and `dq_oe` stays 0.
- R8: In test mode, a read drives each `dq_out[i]` to 1 when `rd_pair[i]` equals `rd_pair[i+8]` and to 0 otherwise, whatever `addr[9]` is.
- R9: In test mode, every write has `arr_half_en`=2'b11.
- R10: The refresh counter is 11 bits wide and wraps. After 2048 counter-driven refreshes, it returns to its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Multiplexed row / column address |
| din | input | 8 | Write data from the pins |
| rd_pair | input | 16 | Array cells for col bit 9 = 0 (low half) and 1 (high half) |
| arr_row | output | 11 | Row index to the array |
| arr_col | output | 9 | Column index to the array, bit 9 dropped |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_half_en | output | 2 | Which cell(s) of the pair to write |
| arr_wdata | output | 8 | Data to write |
| dq_out | output | 8 | Read data or test compare result |
| dq_oe | output | 1 | Output drive enable; 0 means high impedance |
| test_mode | output | 1 | Latched test mode flag |
| cyc_type | output | 3 | Last decoded cycle: 0 none, 1 read, 2 write, 3 row-only refresh, 4 refresh, 5 test entry |
| cyc_valid | output | 1 | One-cycle pulse when `cyc_type` is updated |

## Verification
The decoder is driven with four strobe orderings:
- row strobe first with a column fall and write-enable high;
- the same with write-enable low;
- the row strobe alone;
- column strobe first, with write-enable high and then low.

Together these separate read, write and the three refresh flavours. Reads with column bit 9 at both values show that half selection works in normal mode and is ignored in test mode. Test-mode reads are done twice: once on a pair with equal halves and once on a pair differing in one bit. This tells a real comparison apart from simple data passing through. Both refresh kinds are used to leave test mode, and a long run of counter-driven refreshes shows that the counter wraps.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [2:0] {
        CYC_NONE  = 3'd0,
        CYC_READ  = 3'd1,
        CYC_WRITE = 3'd2,
        CYC_ROR   = 3'd3,
        CYC_CBR   = 3'd4,
        CYC_TEST  = 3'd5
    } cyc_e;
endpackage

// File: rtl/dcd_strobe_edges.sv
module dcd_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall
);
    typedef struct packed {
        logic ras;
        logic cas;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.ras = ras_n;
        prev_d.cas = cas_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '{ras: 1'b1, cas: 1'b1};
        else        prev_q <= prev_d;
    end

    assign ras_fall = prev_q.ras & ~ras_n;
    assign ras_rise = ~prev_q.ras & ras_n;
    assign cas_fall = prev_q.cas & ~cas_n;
endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dcd_pair_compress.sv
module dcd_pair_compress #(
    parameter int DQ_W = 8
) (
    input  logic              test_en,
    input  logic              sel_hi,
    input  logic [2*DQ_W-1:0] pair,
    output logic [DQ_W-1:0]   dq
);
    for (genvar i = 0; i < DQ_W; i++) begin : g_bit
        logic lo_b, hi_b;
        assign lo_b  = pair[i];
        assign hi_b  = pair[DQ_W+i];
        assign dq[i] = test_en ? ~(lo_b ^ hi_b) : (sel_hi ? hi_b : lo_b);
    end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 10,
    parameter int DQ_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [ROW_W-1:0]   addr,
    input  logic [DQ_W-1:0]    din,
    input  logic [2*DQ_W-1:0]  rd_pair,
    output logic [ROW_W-1:0]   arr_row,
    output logic [COL_W-2:0]   arr_col,
    output logic               arr_we,
    output logic [1:0]         arr_half_en,
    output logic [DQ_W-1:0]    arr_wdata,
    output logic [DQ_W-1:0]    dq_out,
    output logic               dq_oe,
    output logic               test_mode,
    output logic [2:0]         cyc_type,
    output logic               cyc_valid
);
    localparam int CI_W = COL_W - 1;

    typedef struct packed {
        logic             tm;
        cyc_e             cyc;
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [CI_W-1:0]  col;
        logic             col_hi;
        logic             cas_seen;
        logic             cbr;
        logic             rd_pend;
        logic [DQ_W-1:0]  dq;
        logic             oe;
        logic             we;
        logic [1:0]       half;
        logic [DQ_W-1:0]  wdata;
    } st_t;

    st_t st_d, st_q;
    logic ras_fall, ras_rise, cas_fall, ctr_inc;
    logic [ROW_W-1:0] ref_cnt;
    logic [DQ_W-1:0]  rd_word;

    dcd_strobe_edges u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall)
    );

    dcd_refresh_ctr #(.CNT_W(ROW_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .cnt(ref_cnt)
    );

    dcd_pair_compress #(.DQ_W(DQ_W)) u_cmp (
        .test_en(st_q.tm), .sel_hi(st_q.col_hi), .pair(rd_pair), .dq(rd_word)
    );

    assign ctr_inc = ras_fall & ~cas_n;

    always_comb begin
        st_d         = st_q;
        st_d.vld     = 1'b0;
        st_d.we      = 1'b0;
        st_d.rd_pend = 1'b0;

        if (st_q.rd_pend) begin
            st_d.dq = rd_word;
            st_d.oe = 1'b1;
        end

        if (ras_fall) begin
            st_d.cas_seen = 1'b0;
            if (!cas_n) begin
                st_d.cbr = 1'b1;
                st_d.row = ref_cnt;
                st_d.vld = 1'b1;
                st_d.oe  = 1'b0;
                if (!we_n) begin
                    st_d.cyc = CYC_TEST;
                    st_d.tm  = 1'b1;
                end else begin
                    st_d.cyc = CYC_CBR;
                    st_d.tm  = 1'b0;
                end
            end else begin
                st_d.cbr = 1'b0;
                st_d.row = addr;
            end
        end else if (cas_fall && !ras_n && !st_q.cbr) begin
            st_d.col      = addr[CI_W-1:0];
            st_d.col_hi   = addr[CI_W];
            st_d.cas_seen = 1'b1;
            st_d.vld      = 1'b1;
            if (!we_n) begin
                st_d.cyc   = CYC_WRITE;
                st_d.we    = 1'b1;
                st_d.wdata = din;
                st_d.oe    = 1'b0;
                st_d.half  = st_q.tm ? 2'b11 : (addr[CI_W] ? 2'b10 : 2'b01);
            end else begin
                st_d.cyc     = CYC_READ;
                st_d.rd_pend = 1'b1;
            end
        end

        if (ras_rise) begin
            st_d.oe  = 1'b0;
            st_d.cbr = 1'b0;
            if (!st_q.cas_seen && !st_q.cbr) begin
                st_d.cyc = CYC_ROR;
                st_d.vld = 1'b1;
                st_d.tm  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_row     = st_q.row;
    assign arr_col     = st_q.col;
    assign arr_we      = st_q.we;
    assign arr_half_en = st_q.half;
    assign arr_wdata   = st_q.wdata;
    assign dq_out      = st_q.dq;
    assign dq_oe       = st_q.oe;
    assign test_mode   = st_q.tm;
    assign cyc_type    = st_q.cyc;
    assign cyc_valid   = st_q.vld;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       test_mode,
    input logic [2:0] cyc_type,
    input logic       cyc_valid,
    input logic       arr_we,
    input logic [1:0] arr_half_en,
    input logic       dq_oe
);
    AST_TEST_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 3'd5) |-> test_mode); // R3
    AST_CBR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 3'd4) |-> !test_mode); // R2
    AST_ROR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 3'd3) |-> !test_mode); // R5
    AST_TM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode != $past(test_mode)) |-> cyc_valid); // R4
    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !dq_oe); // R7
    AST_WRITE_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !test_mode) |-> ($countones(arr_half_en) == 1)); // R7
    AST_TEST_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && test_mode) |-> (arr_half_en == 2'b11)); // R9
endmodule

bind dram_cycle_decoder dcd_checker u_dcd_checker (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .cyc_type(cyc_type),
    .cyc_valid(cyc_valid), .arr_we(arr_we), .arr_half_en(arr_half_en), .dq_oe(dq_oe)
);

// File: tb/dram_cycle_decoder_tb_top.sv
module dram_cycle_decoder_tb_top;
    localparam int ROW_W = 11;
    localparam int COL_W = 10;
    localparam int DQ_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [ROW_W-1:0] addr = '0;
    logic [DQ_W-1:0]  din = '0;
    logic [2*DQ_W-1:0] rd_pair;
    logic [ROW_W-1:0] arr_row;
    logic [COL_W-2:0] arr_col;
    logic arr_we, dq_oe, test_mode, cyc_valid;
    logic [1:0] arr_half_en;
    logic [DQ_W-1:0] arr_wdata, dq_out;
    logic [2:0] cyc_type;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [ROW_W-1:0] exp_cnt = '0;

    logic [2*DQ_W-1:0] mem [16];

    always #10 clk = ~clk;

    dram_cycle_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .rd_pair(rd_pair), .arr_row(arr_row),
        .arr_col(arr_col), .arr_we(arr_we), .arr_half_en(arr_half_en),
        .arr_wdata(arr_wdata), .dq_out(dq_out), .dq_oe(dq_oe),
        .test_mode(test_mode), .cyc_type(cyc_type), .cyc_valid(cyc_valid)
    );

    assign rd_pair = mem[{arr_row[1:0], arr_col[1:0]}];

    always @(posedge clk) begin
        if (arr_we) begin
            if (arr_half_en[0]) mem[{arr_row[1:0], arr_col[1:0]}][DQ_W-1:0] <= arr_wdata;
            if (arr_half_en[1]) mem[{arr_row[1:0], arr_col[1:0]}][2*DQ_W-1:DQ_W] <= arr_wdata;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic release_all();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        tick();
    endtask

    task automatic do_read(int row, int col, logic [DQ_W-1:0] exp, string req);
        addr = ROW_W'(row); ras_n = 1'b0; tick();
        addr = ROW_W'(col); cas_n = 1'b0; we_n = 1'b1; tick();
        chk({req, " read type"}, {31'd0, cyc_valid} << 3 | cyc_type, 32'd9);
        tick();
        chk({req, " read oe"}, dq_oe, 1);
        chk({req, " read data"}, dq_out, exp);
        release_all();
        chk("R6 oe off after row rise", dq_oe, 0);
    endtask

    task automatic do_write(int row, int col, logic [DQ_W-1:0] d, logic [1:0] exp_half, string req);
        addr = ROW_W'(row); ras_n = 1'b0; tick();
        addr = ROW_W'(col); din = d; we_n = 1'b0; tick();
        cas_n = 1'b0; tick();
        chk({req, " write type"}, {31'd0, cyc_valid} << 3 | cyc_type, 32'd10);
        chk({req, " write strobe"}, arr_we, 1);
        chk({req, " write half"}, arr_half_en, exp_half);
        chk({req, " write data"}, arr_wdata, d);
        chk("R7 write keeps hiz", dq_oe, 0);
        release_all();
    endtask

    task automatic do_cbr(logic we, logic exp_tm, string req);
        cas_n = 1'b0; tick();
        we_n = we; ras_n = 1'b0; tick();
        chk({req, " cbr type"}, {31'd0, cyc_valid} << 3 | cyc_type, we ? 32'd12 : 32'd13);
        chk({req, " cbr row"}, arr_row, exp_cnt);
        chk({req, " cbr test flag"}, test_mode, exp_tm);
        exp_cnt++;
        release_all();
    endtask

    task automatic do_ror(int row);
        addr = ROW_W'(row); ras_n = 1'b0; tick(2);
        ras_n = 1'b1; tick();
        chk("R5 row-only type", {31'd0, cyc_valid} << 3 | cyc_type, 32'd11);
        chk("R5 row-only clears test", test_mode, 0);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R1 reset test", test_mode, 0);
        chk("R1 reset oe", dq_oe, 0);
        chk("R1 reset type", {31'd0, cyc_valid} << 3 | cyc_type, 0);
        rst_n = 1'b1; tick();
        chk("R1 after reset type", {31'd0, cyc_valid} << 3 | cyc_type, 0);
    endtask

    task automatic t_normal();
        do_read(1, 2, 8'h56, "R6 low half");
        do_read(1, 10'h202, 8'hA6, "R6 high half");
        do_write(2, 1, 8'h3C, 2'b01, "R7");
        do_read(2, 1, 8'h3C, "R7 readback low");
        do_read(2, 10'h201, 8'hA9, "R7 other half kept");
        do_write(2, 10'h203, 8'hC3, 2'b10, "R7 high");
        do_read(2, 10'h203, 8'hC3, "R7 readback high");
    endtask

    task automatic t_refresh();
        do_ror(5);
        do_cbr(1'b1, 1'b0, "R2 first");
        do_cbr(1'b1, 1'b0, "R2 second");
    endtask

    task automatic t_test_mode();
        do_cbr(1'b0, 1'b1, "R3 entry");
        do_write(3, 0, 8'h5A, 2'b11, "R9");
        chk("R4 test kept after write", test_mode, 1);
        do_read(3, 10'h200, 8'hFF, "R8 equal pair");
        chk("R4 test kept after read", test_mode, 1);
        do_cbr(1'b1, 1'b0, "R2 exit");
        do_write(3, 0, 8'h5B, 2'b01, "R7 diff");
        do_cbr(1'b0, 1'b1, "R3 reentry");
        do_read(3, 0, 8'hFE, "R8 differing pair");
        do_read(3, 10'h200, 8'hFE, "R8 col9 ignored");
        do_ror(6);
    endtask

    task automatic t_wrap();
        logic [ROW_W-1:0] start;
        start = exp_cnt;
        for (int i = 0; i < (1 << ROW_W); i++) begin
            cas_n = 1'b0; tick();
            ras_n = 1'b0; tick();
            release_all();
        end
        exp_cnt = start;
        do_cbr(1'b1, 1'b0, "R10 wrap");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = {8'hA0 + 8'(i), 8'h50 + 8'(i)};
        t_reset();
        t_normal();
        t_refresh();
        t_test_mode();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule